// File: doc/BRIEF.md
# Pattern-Locked Bit Error Rate Receiver

This block is the receive half of a bit error rate tester. It watches a serial stream, one bit per cycle when `valid_i` is high, and locks a local reference to it for the selected test pattern. Once locked, the reference runs on its own, and every later bit is compared against the predicted bit. The block counts the bits compared and the mismatches. Software divides the two counts to get the error ratio.

A start pulse clears the statistics, forces a fresh hunt and loads a test interval. A slow prescaled `tick_i` counts the interval down, and the count of ticks spent without lock is kept alongside. When the interval reaches zero the statistics freeze so they can be read at leisure. If the stream degrades badly enough to break lock, the receiver drops back to hunting by itself and relocks when clean data returns. No operator action is needed.

Top module: `bert_rx`

## Requirements
- R1: `pat_sel_i` selects the pattern. Let h[k] denote the received bit k+1 positions before the current one. The encodings are:
  - 0: 2^11-1 sequence, predicted bit h[10]^h[8].
  - 1: 2^20-1 sequence, h[19]^h[2].
  - 2: 2^23-1 sequence, h[22]^h[17].
  - 3: all ones.
  - 4: all zeros.
  - 5: alternating, the inverse of h[0].
  - 6: one-in-eight, which predicts 1 exactly when h[6:0] are all zero.
  - 7: behaves as all zeros.
- R2: While hunting, the reference history is loaded from the received bits. `sync_o` rises after 32 consecutive valid bits whose prediction matched.
- R3: While locked, the history is fed from the block's own predictions. A single corrupted bit therefore adds exactly one error and does not disturb later comparisons.
- R4: Once locked, compared bits are grouped in back-to-back windows of 64, starting at lock. When 16 errors occur within one window, lock is dropped and hunting resumes automatically. Clean data then relocks the block per R2.
- R5: While the interval is running and the block is locked, each valid bit increments `bit_cnt_o`, and each mismatching one also increments `err_cnt_o`. Bits received while hunting are not counted.
- R6: All three counters saturate at their all-ones value instead of wrapping.
- R7: A start pulse clears all three counters, loads `remain_o` from `interval_i` and forces hunting.
- R8: While `remain_o` is nonzero, each `tick_i` decrements it. A tick taken while not locked also increments `oos_cnt_o`.
- R9: When `remain_o` is zero, all three counters hold their values.
- R10: After reset, every output is zero.
- R11: `sync_o` reports the lock state at all times, whether or not an interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A received bit is present this cycle |
| bit_i | input | 1 | Received bit |
| pat_sel_i | input | 3 | Pattern select (R1) |
| start_i | input | 1 | Start pulse: clear, load interval, hunt |
| tick_i | input | 1 | Prescaled time unit strobe |
| interval_i | input | TIME_W | Test interval in ticks |
| sync_o | output | 1 | Pattern lock status |
| bit_cnt_o | output | CNT_W | Bits compared while locked |
| err_cnt_o | output | CNT_W | Bit errors while locked |
| oos_cnt_o | output | CNT_W | Ticks spent out of lock |
| remain_o | output | TIME_W | Ticks left in the interval |

## Verification
A wrong tap or a corrupted history shows as a lock that never arrives on a clean stream. It can also show as a flood of errors right after lock that drops `sync_o` within one 64-bit window. A window counter that is off shows as loss of lock too early or too late during an error burst, visible at `sync_o` on the bit that crosses the threshold. Counter faults appear in `bit_cnt_o` and `err_cnt_o` one cycle after the offending bit. The bench predicts every output cycle by cycle from the stated rules, so any divergence is caught on the edge where it happens.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  localparam int unsigned HIST_W = 23;

  typedef enum logic [2:0] {
    PAT_PRBS11 = 3'd0,
    PAT_PRBS20 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_ONES   = 3'd3,
    PAT_ZEROS  = 3'd4,
    PAT_ALT    = 3'd5,
    PAT_ONE8   = 3'd6,
    PAT_RSVD   = 3'd7
  } pat_e;

  // h[0] is the most recent bit
  function automatic logic predict(pat_e p, logic [HIST_W-1:0] h);
    logic r;
    case (p)
      PAT_PRBS11: r = h[10] ^ h[8];
      PAT_PRBS20: r = h[19] ^ h[2];
      PAT_PRBS23: r = h[22] ^ h[17];
      PAT_ONES:   r = 1'b1;
      PAT_ALT:    r = ~h[0];
      PAT_ONE8:   r = (h[6:0] == 7'd0);
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bert_ref_gen.sv
module bert_ref_gen
  import bert_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  input  pat_e pat_i,
  input  logic locked_i,
  output logic err_o
);

  logic [HIST_W-1:0] hist_q;
  logic              pred;

  assign pred  = predict(pat_i, hist_q);
  assign err_o = valid_i & (bit_i ^ pred);

  // hunting: load from line; locked: free-run on own prediction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (valid_i) hist_q <= {hist_q[HIST_W-2:0], locked_i ? pred : bit_i};
  end

  // R3: a line error does not enter the locked history
  a_r3_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && err_o) |=> (hist_q[0] != $past(bit_i)));

endmodule

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm #(
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned LOSS_ERRS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic err_i,
  input  logic start_i,
  output logic locked_o
);

  localparam int unsigned MW = $clog2(SYNC_LEN + 1);
  localparam int unsigned WW = $clog2(WIN_LEN);
  localparam int unsigned EW = $clog2(LOSS_ERRS + 1);

  logic          locked_q;
  logic [MW-1:0] match_q;
  logic [WW-1:0] win_q;
  logic [EW-1:0] werr_q, werr_nxt;

  assign werr_nxt = werr_q + EW'(err_i);
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      match_q  <= '0;
      win_q    <= '0;
      werr_q   <= '0;
    end else if (start_i) begin
      locked_q <= 1'b0;
      match_q  <= '0;
    end else if (valid_i) begin
      if (!locked_q) begin
        if (err_i) begin
          match_q <= '0;
        end else if (match_q == MW'(SYNC_LEN - 1)) begin
          locked_q <= 1'b1;
          match_q  <= '0;
          win_q    <= '0;
          werr_q   <= '0;
        end else begin
          match_q <= match_q + 1'b1;
        end
      end else begin
        if (werr_nxt == EW'(LOSS_ERRS)) begin
          locked_q <= 1'b0;
          match_q  <= '0;
        end else if (win_q == WW'(WIN_LEN - 1)) begin
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          win_q  <= win_q + 1'b1;
          werr_q <= werr_nxt;
        end
      end
    end
  end

  // R2: lock is entered only on a correctly predicted bit
  a_r2_lock_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(valid_i) && !$past(err_i)));

  // R4: lock is dropped only by an error or a start
  a_r4_loss_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> ($past(start_i) || $past(valid_i && err_i)));

  // R4: window error count never reaches the threshold while locked
  a_r4_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> (werr_q < EW'(LOSS_ERRS)));

endmodule

// File: rtl/bert_stats.sv
module bert_stats #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic              locked_i,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] interval_i,
  output logic [CNT_W-1:0]  bits_o,
  output logic [CNT_W-1:0]  errs_o,
  output logic [CNT_W-1:0]  oos_o,
  output logic [TIME_W-1:0] remain_o
);

  logic [CNT_W-1:0]  bits_q, errs_q, oos_q;
  logic [TIME_W-1:0] remain_q;
  logic              running;

  assign running = (remain_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q   <= '0;
      errs_q   <= '0;
      oos_q    <= '0;
      remain_q <= '0;
    end else if (start_i) begin
      bits_q   <= '0;
      errs_q   <= '0;
      oos_q    <= '0;
      remain_q <= interval_i;
    end else if (running) begin
      if (valid_i && locked_i) begin
        if (!(&bits_q)) bits_q <= bits_q + 1'b1;
        if (err_i && !(&errs_q)) errs_q <= errs_q + 1'b1;
      end
      if (tick_i) begin
        remain_q <= remain_q - 1'b1;
        if (!locked_i && !(&oos_q)) oos_q <= oos_q + 1'b1;
      end
    end
  end

  assign bits_o   = bits_q;
  assign errs_o   = errs_q;
  assign oos_o    = oos_q;
  assign remain_o = remain_q;

  // R6: saturated bit count holds
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&bits_q) && !start_i) |=> (&bits_q));

  // R5: errors never exceed bits compared
  a_r5_err_le_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    errs_q <= bits_q);

  // R9: counters frozen once the interval has run out
  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !start_i) |=> ($stable(bits_q) && $stable(errs_q) && $stable(oos_q)));

  // R8: interval only counts down
  a_r8_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (remain_q <= $past(remain_q)));

endmodule

// File: rtl/bert_rx.sv
module bert_rx
  import bert_rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned TIME_W    = 16,
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned LOSS_ERRS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic [2:0]        pat_sel_i,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] interval_i,
  output logic              sync_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [CNT_W-1:0]  oos_cnt_o,
  output logic [TIME_W-1:0] remain_o
);

  logic locked, err;

  bert_ref_gen u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .bit_i    (bit_i),
    .pat_i    (pat_e'(pat_sel_i)),
    .locked_i (locked),
    .err_o    (err)
  );

  bert_sync_fsm #(
    .SYNC_LEN  (SYNC_LEN),
    .WIN_LEN   (WIN_LEN),
    .LOSS_ERRS (LOSS_ERRS)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .err_i    (err),
    .start_i  (start_i),
    .locked_o (locked)
  );

  bert_stats #(
    .CNT_W  (CNT_W),
    .TIME_W (TIME_W)
  ) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .err_i      (err),
    .locked_i   (locked),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .interval_i (interval_i),
    .bits_o     (bit_cnt_o),
    .errs_o     (err_cnt_o),
    .oos_o      (oos_cnt_o),
    .remain_o   (remain_o)
  );

  assign sync_o = locked;

  // R7: a start always leaves the block hunting
  a_r7_start_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sync_o);

endmodule

// File: tb/bert_rx_bench.sv
module bert_rx_bench;
  localparam int TIME_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              valid = 1'b0, bitv = 1'b0, start = 1'b0, tick = 1'b0;
  logic [2:0]        pat_sel = 3'd0;
  logic [TIME_W-1:0] interval = '0;
  logic              sync;
  logic [31:0]       bit_cnt, err_cnt, oos_cnt;
  logic [TIME_W-1:0] remain;
  logic              s_sync;
  logic [7:0]        s_bits, s_errs, s_oos;
  logic [TIME_W-1:0] s_rem;

  bert_rx u_bert_rx (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bitv),
    .pat_sel_i(pat_sel), .start_i(start), .tick_i(tick), .interval_i(interval),
    .sync_o(sync), .bit_cnt_o(bit_cnt), .err_cnt_o(err_cnt),
    .oos_cnt_o(oos_cnt), .remain_o(remain)
  );

  bert_rx #(.CNT_W(8)) u_bert_rx_sat (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bitv),
    .pat_sel_i(pat_sel), .start_i(start), .tick_i(tick), .interval_i(interval),
    .sync_o(s_sync), .bit_cnt_o(s_bits), .err_cnt_o(s_errs),
    .oos_cnt_o(s_oos), .remain_o(s_rem)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [22:0] m_hist = '0;
  logic        m_sync = 1'b0;
  int          m_match = 0, m_win = 0, m_werr = 0;
  logic [31:0] m_bits = '0, m_errs = '0, m_oos = '0;
  int          m_rem = 0;
  // transmitter state
  logic [22:0] t_hist = '0;
  logic [2:0]  cur_pat = 3'd0;

  function automatic logic ref_bit(logic [2:0] p, logic [22:0] h);
    case (p)
      3'd0: return h[10] ^ h[8];
      3'd1: return h[19] ^ h[2];
      3'd2: return h[22] ^ h[17];
      3'd3: return 1'b1;
      3'd5: return ~h[0];
      3'd6: return h[6:0] == 7'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] sat_inc(logic [31:0] v);
    return (v == 32'hFFFF_FFFF) ? v : v + 1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic pred, err, run, old_sync;
    pred = ref_bit(pat_sel, m_hist);
    err = valid && (bitv ^ pred);
    run = (m_rem != 0);
    old_sync = m_sync;
    if (start) begin
      m_bits = 0; m_errs = 0; m_oos = 0; m_rem = int'(interval);
    end else if (run) begin
      if (valid && old_sync) begin
        m_bits = sat_inc(m_bits);
        if (err) m_errs = sat_inc(m_errs);
      end
      if (tick) begin
        m_rem--;
        if (!old_sync) m_oos = sat_inc(m_oos);
      end
    end
    if (valid) m_hist = {m_hist[21:0], old_sync ? pred : bitv};
    if (start) begin
      m_sync = 1'b0; m_match = 0;
    end else if (valid) begin
      if (!old_sync) begin
        if (err) m_match = 0;
        else if (m_match == 31) begin
          m_sync = 1'b1; m_match = 0; m_win = 0; m_werr = 0;
        end else m_match++;
      end else begin
        if (m_werr + int'(err) == 16) begin
          m_sync = 1'b0; m_match = 0;
        end else if (m_win == 63) begin
          m_win = 0; m_werr = 0;
        end else begin
          m_win++; m_werr += int'(err);
        end
      end
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(bit v, bit flip, bit t, bit s);
    logic b;
    valid = v; tick = t; start = s;
    if (v) begin
      b = ref_bit(cur_pat, t_hist);
      t_hist = {t_hist[21:0], b};
      bitv = b ^ flip;
    end else bitv = 1'($urandom_range(0, 1));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R11 sync", 32'(sync), 32'(m_sync));
    check("R5 bit_cnt", bit_cnt, m_bits);
    check("R5 err_cnt", err_cnt, m_errs);
    check("R8 oos_cnt", oos_cnt, m_oos);
    check("R8 remain", 32'(remain), 32'(m_rem));
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] e0, fb, fe, fo;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R10 sync", 32'(sync), 0);
    check("R10 bit_cnt", bit_cnt, 0);
    check("R10 err_cnt", err_cnt, 0);
    check("R10 oos_cnt", oos_cnt, 0);
    check("R10 remain", 32'(remain), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 7; p++) begin
      cur_pat = 3'(p);
      pat_sel = 3'(p);
      t_hist = (p < 3) ? (23'($urandom) | 23'd1) : 23'd0;
      interval = 16'd3000;
      step(0, 0, 0, 1);
      repeat (160) step($urandom_range(0, 99) < 80, 0, $urandom_range(0, 99) < 5, 0);
      check("R1 R2 locked on clean stream", 32'(sync), 1);
      e0 = err_cnt;
      step(1, 1, 0, 0);
      repeat (30) step(1, 0, 0, 0);
      check("R3 single error counted once", err_cnt - e0, 1);
      check("R3 lock kept", 32'(sync), 1);
      repeat (300) step($urandom_range(0, 99) < 85, $urandom_range(0, 99) < 2,
                       $urandom_range(0, 99) < 5, 0);
      repeat (40) step(1, 1, 0, 0);
      check("R4 lock lost after burst", 32'(sync), 0);
      repeat (90) step(1, 0, $urandom_range(0, 99) < 5, 0);
      check("R4 relock", 32'(sync), 1);
    end

    // R7: start clears and forces hunt
    cur_pat = 3'd3; pat_sel = 3'd3;
    interval = 16'd4;
    step(0, 0, 0, 1);
    check("R7 bits cleared", bit_cnt, 0);
    check("R7 errs cleared", err_cnt, 0);
    check("R7 hunting", 32'(sync), 0);
    check("R7 interval loaded", 32'(remain), 4);
    // R8: ticks while hunting count as out of sync
    repeat (3) step(0, 0, 1, 0);
    check("R8 oos ticks", oos_cnt, 3);
    check("R8 remain after ticks", 32'(remain), 1);
    repeat (40) step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    check("R8 interval expired", 32'(remain), 0);
    fb = bit_cnt; fe = err_cnt; fo = oos_cnt;
    repeat (50) step(1, $urandom_range(0, 1), 1, 0);
    check("R9 bits frozen", bit_cnt, fb);
    check("R9 errs frozen", err_cnt, fe);
    check("R9 oos frozen", oos_cnt, fo);
    check("R11 sync still reported", 32'(sync), 32'(m_sync));

    // R6: saturation on the narrow instance
    interval = 16'd1000;
    step(0, 0, 0, 1);
    repeat (400) step(1, 0, 0, 0);
    check("R6 narrow bit count saturates", 32'(s_bits), 255);
    check("R6 wide count keeps going", 32'(bit_cnt > 32'd255), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule